// File: doc/BRIEF.md
# Set-Associative Write-Back Cache Controller

This block sits between a processor load/store port and a block-wide memory port. A 32-bit address is split into three fields: a byte offset inside the block, a set index, and a tag made of the remaining high bits. All ways of the indexed set are compared at the same time. A hit completes in the cycle it is presented. A write hit changes only the cached copy and marks the line modified.

On a miss the controller holds the processor stalled and chooses a victim line. If the victim is modified, the controller first hands it to an eviction port in a single-cycle transfer. It then requests the missing block from memory. When the block arrives it is installed clean, and the stalled request is retried as a hit. A write miss therefore allocates the block first and then applies the write on the retry.

Victim choice takes any invalid way first. Once the set is full, a run-time mode input selects one of three rules:
- a free-running counter shared by all sets,
- a per-set oldest-first pointer,
- a per-set recency bit, used for two-way configurations.

Top module: `wbc_cache_ctrl`

## Requirements
- R1: Bits [OFF_BITS-1:0] of an address are the byte offset, bits [OFF_BITS+SET_BITS-1:OFF_BITS] the set index, and bits [31:OFF_BITS+SET_BITS] the tag. The 32-bit word within the block is selected by bits [OFF_BITS-1:2]. Fetch and eviction addresses are block aligned: {tag, set, zero offset}.
- R2: A request hits only when some way of its set is valid and holds its tag. A hit has req_stall low in the cycle the request is presented. A read hit returns the selected word on req_rdata in that same cycle.
- R3: On a miss, req_stall is high from the cycle the request is presented until the fill completes. mem_rd_req stays high with a stable mem_rd_addr until mem_rd_valid. The block on mem_rd_data is then installed valid and clean under the request tag, and the held request hits in the following cycle.
- R4: A write hit updates only the cached word and marks the line modified. It causes no eviction and no fetch.
- R5: A write miss fetches the whole block as a read miss would, then applies the write. Later reads see the new word in that position and the fetched data in all other positions.
- R6: A modified victim is presented for exactly one cycle on evict_valid, evict_addr and evict_data, and the fetch starts in the next cycle. A clean victim is dropped with no eviction.
- R7: When the set has an invalid way, the lowest-numbered invalid way is filled, whatever the replacement mode.
- R8: Random mode (repl_mode 2'b00 or 2'b11): a counter shared by all sets runs 0..WAYS-1 and advances on every clock edge after reset. The victim is the counter value in the cycle the miss is presented.
- R9: Oldest-first mode (repl_mode 2'b01): each set keeps a pointer that starts at way 0 and advances by one, wrapping at WAYS, on every fill of that set. The victim is the way the pointer names.
- R10: Recency mode (repl_mode 2'b10, two ways): each set keeps one bit naming its less recently used way. The bit is updated on every hit and on every fill, and the victim is the way it names. With other way counts this mode behaves as oldest-first.
- R11: After reset every line is invalid and all counters are zero. With no request presented, req_stall, evict_valid and mem_rd_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| repl_mode | input | 2 | Replacement rule: 00/11 random, 01 oldest-first, 10 recency |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address of the request |
| req_wdata | input | 32 | Store data |
| req_stall | output | 1 | Request cannot complete this cycle |
| req_rdata | output | 32 | Load data, valid when a read request is not stalled |
| evict_valid | output | 1 | Modified victim presented this cycle |
| evict_addr | output | 32 | Block address of the evicted line |
| evict_data | output | 32*2^(OFF_BITS-2) | Evicted block contents |
| mem_rd_req | output | 1 | Block fetch outstanding |
| mem_rd_addr | output | 32 | Block address being fetched |
| mem_rd_valid | input | 1 | Fetched block present on mem_rd_data |
| mem_rd_data | input | 32*2^(OFF_BITS-2) | Fetched block contents |

## Verification
The assertions assume the processor keeps address, direction and store data unchanged while req_stall is high. They also assume that memory raises mem_rd_valid only while mem_rd_req is high. The fetch-address property depends on the first of these. The bench presents each request once and holds it until the stall drops. It answers a fetch only after it sees mem_rd_req, after a random wait of zero to two cycles, and it drops mem_rd_valid after a single cycle. Random addresses come from a small tag pool spread over every set, so conflict misses, dirty evictions and mode switches happen often.

// File: rtl/wbc_pkg.sv
`timescale 1ns/1ps
package wbc_pkg;
    typedef enum logic [1:0] {
        POL_RANDOM     = 2'b00,
        POL_FIFO       = 2'b01,
        POL_RECENT     = 2'b10,
        POL_RANDOM_ALT = 2'b11
    } repl_mode_e;

    typedef enum logic [1:0] {
        ST_LOOKUP    = 2'b00,
        ST_WRITEBACK = 2'b01,
        ST_REFILL    = 2'b10
    } ctrl_state_e;
endpackage

// File: rtl/wbc_tag_match.sv
`timescale 1ns/1ps
module wbc_tag_match #(
    parameter int WAYS     = 2,
    parameter int TAG_BITS = 27,
    localparam int WW      = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]               line_valid,
    input  logic [WAYS-1:0][TAG_BITS-1:0] line_tag,
    input  logic [TAG_BITS-1:0]           probe_tag,
    output logic                          hit,
    output logic [WW-1:0]                 hit_way
);
    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = line_valid[w] && (line_tag[w] == probe_tag);
    end

    always_comb begin
        hit     = |match;
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way = WW'(w);
        end
    end
endmodule

// File: rtl/wbc_victim_pick.sv
`timescale 1ns/1ps
module wbc_victim_pick
    import wbc_pkg::*;
#(
    parameter int WAYS = 2,
    localparam int WW  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0] line_valid,
    input  logic [1:0]      mode,
    input  logic [WW-1:0]   rnd_way,
    input  logic [WW-1:0]   fifo_way,
    input  logic            lru_bit,
    output logic [WW-1:0]   victim
);
    if (WAYS == 1) begin : g_direct
        logic unused_pick_inputs;
        assign unused_pick_inputs = ^{line_valid, mode, rnd_way, fifo_way, lru_bit};
        assign victim = '0;
    end else begin : g_assoc
        logic [WW-1:0] policy_way;
        logic          found;
        always_comb begin
            unique case (repl_mode_e'(mode))
                POL_FIFO:   policy_way = fifo_way;
                POL_RECENT: policy_way = (WAYS == 2) ? WW'(lru_bit) : fifo_way;
                default:    policy_way = rnd_way;
            endcase
            victim = policy_way;
            found  = 1'b0;
            for (int w = 0; w < WAYS; w++) begin
                if (!found && !line_valid[w]) begin
                    victim = WW'(w);
                    found  = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/wbc_cache_ctrl.sv
`timescale 1ns/1ps
module wbc_cache_ctrl
    import wbc_pkg::*;
#(
    parameter int WAYS     = 2,
    parameter int SET_BITS = 2,
    parameter int OFF_BITS = 3,
    localparam int SETS     = 1 << SET_BITS,
    localparam int WORDS    = 1 << (OFF_BITS - 2),
    localparam int BLK      = 32 * WORDS,
    localparam int TAG_BITS = 32 - SET_BITS - OFF_BITS,
    localparam int WW       = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int WDW      = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      repl_mode,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [31:0]     req_addr,
    input  logic [31:0]     req_wdata,
    output logic            req_stall,
    output logic [31:0]     req_rdata,
    output logic            evict_valid,
    output logic [31:0]     evict_addr,
    output logic [BLK-1:0]  evict_data,
    output logic            mem_rd_req,
    output logic [31:0]     mem_rd_addr,
    input  logic            mem_rd_valid,
    input  logic [BLK-1:0]  mem_rd_data
);
    typedef struct packed {
        ctrl_state_e                              st;
        logic [TAG_BITS-1:0]                      mtag;
        logic [SET_BITS-1:0]                      mset;
        logic [WW-1:0]                            vic;
        logic [WW-1:0]                            rnd;
        logic [SETS-1:0][WW-1:0]                  fifo;
        logic [SETS-1:0]                          lru;
        logic [SETS-1:0][WAYS-1:0]                valid;
        logic [SETS-1:0][WAYS-1:0]                dirty;
        logic [SETS-1:0][WAYS-1:0][TAG_BITS-1:0]  tag;
        logic [SETS-1:0][WAYS-1:0][WORDS-1:0][31:0] data;
    } regs_t;

    regs_t s_d, s_q;

    logic [TAG_BITS-1:0] a_tag;
    logic [SET_BITS-1:0] a_set;
    logic [WDW-1:0]      a_word;
    logic                hit;
    logic [WW-1:0]       hit_way;
    logic [WW-1:0]       vic_way;
    logic                unused_byte_bits;

    assign a_tag  = req_addr[31 -: TAG_BITS];
    assign a_set  = req_addr[OFF_BITS +: SET_BITS];
    assign a_word = req_addr[2 +: WDW];
    assign unused_byte_bits = ^req_addr[1:0];

    wbc_tag_match #(.WAYS(WAYS), .TAG_BITS(TAG_BITS)) u_match (
        .line_valid (s_q.valid[a_set]),
        .line_tag   (s_q.tag[a_set]),
        .probe_tag  (a_tag),
        .hit        (hit),
        .hit_way    (hit_way)
    );

    wbc_victim_pick #(.WAYS(WAYS)) u_pick (
        .line_valid (s_q.valid[a_set]),
        .mode       (repl_mode),
        .rnd_way    (s_q.rnd),
        .fifo_way   (s_q.fifo[a_set]),
        .lru_bit    (s_q.lru[a_set]),
        .victim     (vic_way)
    );

    assign req_rdata   = s_q.data[a_set][hit_way][a_word];
    assign evict_addr  = {s_q.tag[s_q.mset][s_q.vic], s_q.mset, {OFF_BITS{1'b0}}};
    assign evict_data  = s_q.data[s_q.mset][s_q.vic];
    assign mem_rd_addr = {s_q.mtag, s_q.mset, {OFF_BITS{1'b0}}};

    always_comb begin
        s_d         = s_q;
        s_d.rnd     = (s_q.rnd == WW'(WAYS - 1)) ? '0 : s_q.rnd + 1'b1;
        req_stall   = 1'b1;
        evict_valid = 1'b0;
        mem_rd_req  = 1'b0;
        unique case (s_q.st)
            ST_LOOKUP: begin
                req_stall = req_valid && !hit;
                if (req_valid && hit) begin
                    if (req_write) begin
                        s_d.data[a_set][hit_way][a_word] = req_wdata;
                        s_d.dirty[a_set][hit_way]        = 1'b1;
                    end
                    s_d.lru[a_set] = ~hit_way[0];
                end else if (req_valid) begin
                    s_d.mtag = a_tag;
                    s_d.mset = a_set;
                    s_d.vic  = vic_way;
                    s_d.st   = (s_q.valid[a_set][vic_way] && s_q.dirty[a_set][vic_way])
                               ? ST_WRITEBACK : ST_REFILL;
                end
            end
            ST_WRITEBACK: begin
                evict_valid = 1'b1;
                s_d.st      = ST_REFILL;
            end
            ST_REFILL: begin
                mem_rd_req = 1'b1;
                if (mem_rd_valid) begin
                    s_d.data[s_q.mset][s_q.vic]  = mem_rd_data;
                    s_d.tag[s_q.mset][s_q.vic]   = s_q.mtag;
                    s_d.valid[s_q.mset][s_q.vic] = 1'b1;
                    s_d.dirty[s_q.mset][s_q.vic] = 1'b0;
                    s_d.fifo[s_q.mset] = (s_q.fifo[s_q.mset] == WW'(WAYS - 1))
                                         ? '0 : s_q.fifo[s_q.mset] + 1'b1;
                    s_d.lru[s_q.mset]  = ~s_q.vic[0];
                    s_d.st             = ST_LOOKUP;
                end
            end
            default: s_d.st = ST_LOOKUP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/wbc_cache_chk.sv
`timescale 1ns/1ps
module wbc_cache_chk #(
    parameter int SET_BITS = 2,
    parameter int OFF_BITS = 3
) (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] req_addr,
    input logic        req_stall,
    input logic        evict_valid,
    input logic [31:0] evict_addr,
    input logic        mem_rd_req,
    input logic [31:0] mem_rd_addr,
    input logic        mem_rd_valid
);
    localparam int HI = OFF_BITS + SET_BITS - 1;

    // R3: an unanswered fetch keeps asking for the same block
    a_r3_fetch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req && !mem_rd_valid |=> mem_rd_req && $stable(mem_rd_addr));

    // R3: the processor is held while a fetch is outstanding
    a_r3_stall_on_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> req_stall);

    // R3: a completed fill ends memory activity for this miss
    a_r3_fill_ends: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req && mem_rd_valid |=> !mem_rd_req && !evict_valid);

    // R6: an eviction lasts one cycle and is followed by the fetch
    a_r6_evict_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid |=> mem_rd_req && !evict_valid);

    // R6: victim and fetched block share the set index
    a_r6_evict_same_set: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid |=> mem_rd_addr[HI:OFF_BITS] == $past(evict_addr[HI:OFF_BITS]));

    // R1: the fetched block is the one holding the stalled request
    a_r1_fetch_matches_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> mem_rd_addr[31:OFF_BITS] == req_addr[31:OFF_BITS]);
endmodule

bind wbc_cache_ctrl wbc_cache_chk #(.SET_BITS(SET_BITS), .OFF_BITS(OFF_BITS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_addr     (req_addr),
    .req_stall    (req_stall),
    .evict_valid  (evict_valid),
    .evict_addr   (evict_addr),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_valid (mem_rd_valid)
);

// File: tb/tb_wbc_cache_ctrl.sv
`timescale 1ns/1ps
module tb_wbc_cache_ctrl;
    localparam int WAYS = 2, SET_BITS = 2, OFF_BITS = 3;
    localparam int SETS = 1 << SET_BITS, WORDS = 1 << (OFF_BITS - 2), BLK = 32 * WORDS;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] repl_mode = 2'b00;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic req_stall, evict_valid, mem_rd_req;
    logic [31:0] req_rdata, evict_addr, mem_rd_addr;
    logic [BLK-1:0] evict_data;
    logic mem_rd_valid = 1'b0;
    logic [BLK-1:0] mem_rd_data = '0;

    always #4 clk = ~clk;

    wbc_cache_ctrl #(.WAYS(WAYS), .SET_BITS(SET_BITS), .OFF_BITS(OFF_BITS)) dut (
        .clk(clk), .rst_n(rst_n), .repl_mode(repl_mode),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_stall(req_stall), .req_rdata(req_rdata),
        .evict_valid(evict_valid), .evict_addr(evict_addr), .evict_data(evict_data),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
    );

    int checks = 0, errors = 0;
    int unsigned cyc = 0;
    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    bit             m_valid [SETS][WAYS];
    bit             m_dirty [SETS][WAYS];
    int unsigned    m_tag   [SETS][WAYS];
    logic [BLK-1:0] m_data  [SETS][WAYS];
    int             m_fifo  [SETS];
    int             m_lru   [SETS];
    logic [BLK-1:0] mem     [int unsigned];

    function automatic logic [31:0] mk_addr(int unsigned t, int s, int w);
        return (t << (OFF_BITS + SET_BITS)) | (32'(s) << OFF_BITS) | (32'(w) << 2);
    endfunction

    function automatic logic [BLK-1:0] mem_read(int unsigned ba);
        logic [BLK-1:0] v;
        if (mem.exists(ba)) return mem[ba];
        for (int i = 0; i < WORDS; i++) v[32*i +: 32] = ba * 32'd2654435761 + 32'(i * 17 + 1);
        return v;
    endfunction

    task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // one processor access; vtag names the requirement behind the victim choice
    task automatic access(bit wr, logic [31:0] a, logic [31:0] wd, string vtag);
        int s, wi, hw, v, guard, lat;
        int unsigned t;
        bit ev_exp, ev_seen;
        s  = int'((a >> OFF_BITS) & (SETS - 1));
        wi = int'((a >> 2) & (WORDS - 1));
        t  = a >> (OFF_BITS + SET_BITS);
        hw = -1;
        for (int w = 0; w < WAYS; w++) if (m_valid[s][w] && m_tag[s][w] == t) hw = w;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        #1;
        if (hw < 0) begin
            v = -1;
            for (int w = 0; w < WAYS; w++) if (v < 0 && !m_valid[s][w]) v = w;
            if (v < 0) begin
                case (repl_mode)
                    2'b01:   v = m_fifo[s];
                    2'b10:   v = m_lru[s];
                    default: v = int'(cyc % WAYS);
                endcase
            end
            chk("R3 stall on miss", req_stall, 1);
            ev_exp = m_valid[s][v] && m_dirty[s][v];
            ev_seen = 0; guard = 0; lat = int'($urandom % 3);
            while (req_stall && guard < 40) begin
                @(negedge clk);
                mem_rd_valid = 1'b0;
                #1;
                guard++;
                if (evict_valid) begin
                    ev_seen = 1;
                    chk({vtag, " victim address"}, evict_addr,
                        (m_tag[s][v] << (OFF_BITS + SET_BITS)) | (32'(s) << OFF_BITS));
                    chk("R6 evicted data", evict_data, m_data[s][v]);
                    mem[evict_addr] = evict_data;
                end
                if (mem_rd_req) begin
                    chk("R1 fetch block address", mem_rd_addr, a & ~32'(WORDS * 4 - 1));
                    if (lat == 0) begin
                        mem_rd_valid = 1'b1;
                        mem_rd_data  = mem_read(mem_rd_addr);
                    end else lat--;
                end
            end
            chk({vtag, " R6 eviction only for modified victim"}, ev_seen, ev_exp);
            chk("R3 stall released after fill", req_stall, 0);
            m_data[s][v]  = mem_read(a & ~32'(WORDS * 4 - 1));
            m_valid[s][v] = 1; m_tag[s][v] = t; m_dirty[s][v] = 0;
            m_fifo[s] = (m_fifo[s] + 1) % WAYS;
            hw = v;
        end else begin
            chk("R2 hit without stall", req_stall, 0);
            chk("R4 no memory traffic on hit", {evict_valid, mem_rd_req}, 0);
        end
        if (!wr) chk("R2 read data", req_rdata, m_data[s][hw][32*wi +: 32]);
        else begin
            m_data[s][hw][32*wi +: 32] = wd;
            m_dirty[s][hw] = 1;
        end
        m_lru[s] = (hw == 0) ? 1 : 0;
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic align(int parity);
        while (int'(cyc % 2) != parity) begin
            @(posedge clk);
            #1;
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] a;
        void'($urandom(32'd20240611));
        for (int s = 0; s < SETS; s++) begin
            m_fifo[s] = 0; m_lru[s] = 0;
            for (int w = 0; w < WAYS; w++) begin
                m_valid[s][w] = 0; m_dirty[s][w] = 0; m_tag[s][w] = 0; m_data[s][w] = '0;
            end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11: idle outputs after reset
        chk("R11 stall idle", req_stall, 0);
        chk("R11 no eviction", evict_valid, 0);
        chk("R11 no fetch", mem_rd_req, 0);
        // R11: first access to an empty cache misses
        access(0, mk_addr(9, 0, 1), 0, "R11");

        // R10 recency, set 3
        repl_mode = 2'b10;
        access(1, mk_addr(1, 3, 0), 32'hAAAA0001, "R10");
        access(1, mk_addr(2, 3, 1), 32'hBBBB0002, "R10");
        access(0, mk_addr(1, 3, 0), 0, "R10");
        access(0, mk_addr(3, 3, 0), 0, "R10");
        access(0, mk_addr(2, 3, 1), 0, "R10");

        // R9 oldest-first, set 2
        repl_mode = 2'b01;
        access(1, mk_addr(1, 2, 0), 32'h11112222, "R9");
        access(1, mk_addr(2, 2, 0), 32'h33334444, "R9");
        access(0, mk_addr(1, 2, 0), 0, "R9");
        access(0, mk_addr(3, 2, 1), 0, "R9");

        // R8 shared random counter, set 1, both parities
        repl_mode = 2'b00;
        access(1, mk_addr(1, 1, 0), 32'h0BADF00D, "R8");
        access(1, mk_addr(2, 1, 1), 32'h0D15EA5E, "R8");
        align(0);
        access(0, mk_addr(3, 1, 0), 0, "R8");
        access(1, mk_addr(3, 1, 0), 32'h13579BDF, "R8");
        align(1);
        access(0, mk_addr(4, 1, 0), 0, "R8");

        // R7 invalid way before counter choice (set 0 has way 0 filled)
        align(0);
        access(0, mk_addr(5, 0, 0), 0, "R7");
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = mk_addr(9, 0, 1);
        #1;
        chk("R7 earlier line kept after invalid way filled", req_stall, 0);
        req_valid = 1'b0;
        access(0, mk_addr(9, 0, 1), 0, "R7");

        // R5 write miss allocates then writes
        repl_mode = 2'b01;
        a = mk_addr(7, 2, 1);
        access(1, a, 32'hCAFE0005, "R5");
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        #1;
        chk("R5 written word visible", req_rdata, 32'hCAFE0005);
        req_valid = 1'b0;
        access(0, mk_addr(7, 2, 0), 0, "R5");

        // random mix
        for (int i = 0; i < 600; i++) begin
            if (i % 64 == 0) repl_mode = 2'($urandom % 4);
            a = mk_addr(1 + $urandom % 5, int'($urandom % SETS), int'($urandom % WORDS));
            access(bit'($urandom % 2), a, $urandom, "R6");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule